// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Handling

This block turns an idle-high asynchronous serial line into a stream of characters. The line is sampled on a clock enable running at sixteen times the bit rate, passed through a two-stage synchronizer, and framed by a small state machine. Characters are 5 to 8 bits long. Each character can carry a parity bit that is checked against an even/odd rule or a forced level, or that is stored as an address/data marker. Each character enters a small receive queue together with three status bits: break, framing error and parity/address.

A break is a line held low through a whole character and its stop bit. It produces exactly one queue entry, however long the line stays low. Reception then stays suspended until the line has been high for half a bit time. A reader sees the queue head on the data and status outputs while the ready flag is set, and advances the queue with a one-cycle pop strobe. A sticky overrun flag records characters that were lost because the queue was full. A clear strobe resets that flag.

Top module: `uart_rx_brk`

## Requirements
- R1: After reset, rxRdy, fifoFull, overrun, rxData and all three status outputs are 0.
- R2: A start bit is accepted only on a high-to-low transition that is still low at the eighth sample enable (mid-bit); a shorter low pulse produces no character.
- R3: Data bits are taken LSB first at mid-bit; charLen selects the length (00=5, 01=6, 10=7, 11=8 bits) and the character appears right-justified on rxData with unused upper bits 0.
- R4: The stop bit is sampled once, at its middle; a low sample sets statFrame for that character.
- R5: parMode 00 checks parity (parOdd=0 even, parOdd=1 odd), 01 expects the parity bit to equal parOdd, 10 has no parity bit; statParity is 1 only when a checked parity bit mismatches.
- R6: With parMode 11 a parity-position bit is still received, and statParity holds its received value instead of an error.
- R7: A character whose data bits, parity bit (if any) and stop bit are all 0 is stored once as data 0 with statBreak=1 and statFrame=1, no matter how long the line stays low.
- R8: After a break, no new start bit is recognized until rxd has been high for 8 consecutive sample enables; a character that begins earlier is lost.
- R9: The queue holds DEPTH entries; rxRdy is 1 while it is non-empty, fifoFull is 1 when it holds DEPTH entries, popReq removes the head, and while rxRdy is 0 the data and status outputs read 0.
- R10: A character that completes while the queue is full is dropped and sets overrun, which stays set; the full check is made before a pop in the same cycle.
- R11: A one-cycle clrErr clears overrun on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Sample enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| charLen | input | 2 | Character length code (5 to 8 bits) |
| parMode | input | 2 | Parity mode: 00 check, 01 forced, 10 none, 11 address/data |
| parOdd | input | 1 | Odd parity select, or forced level in mode 01 |
| popReq | input | 1 | Remove the queue head |
| clrErr | input | 1 | Clear the overrun flag |
| rxData | output | 8 | Head character, right-justified |
| statBreak | output | 1 | Head entry is a break |
| statFrame | output | 1 | Head entry had a low stop bit |
| statParity | output | 1 | Parity error, or address/data bit in mode 11 |
| rxRdy | output | 1 | Queue not empty |
| fifoFull | output | 1 | Queue full |
| overrun | output | 1 | Sticky lost-character flag |

## Verification
The bench holds the line low through a long break to show that a block which pushes once per zero character, instead of once per break, would fill the queue with copies. It then releases the line for less than half a bit before a new character, so a design that restarts reception too early would store that character. A short low glitch probes the mid-bit start check, because a receiver that trusts the first falling edge would frame garbage. The bench also overfills the queue to show that the fifth character is dropped and not written over the oldest. Parity is checked in all four modes with both correct and wrong bits, so that an inverted even/odd rule or a multidrop bit treated as an error would show up in statParity.

// File: rtl/uartrx_pkg.sv
package uartrx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_BRK
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearShift;
    logic shiftBit;
    logic latchPar;
    logic push;
  } rxStrobe_t;

  // one queue entry
  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rxEntry_t;

  localparam int ENTRY_W = $bits(rxEntry_t);

endpackage

// File: rtl/uartrx_ctrl.sv
module uartrx_ctrl
  import uartrx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  input  logic       rxS,
  input  logic       charZero,
  input  logic [1:0] charLen,
  input  logic       parOn,
  output rxStrobe_t  strb
);

  localparam int TW = $clog2(OVS);
  localparam logic [TW-1:0] LAST = TW'(OVS - 1);
  localparam logic [TW-1:0] MID  = TW'(OVS / 2 - 1);

  rxState_t      state, stateNxt;
  logic [TW-1:0] tick, tickNxt;
  logic [2:0]    bitIdx, bitIdxNxt;
  logic          lastS;
  logic [2:0]    lastIdx;

  assign lastIdx = 3'd4 + {1'b0, charLen};

  always_comb begin
    stateNxt  = state;
    tickNxt   = tick;
    bitIdxNxt = bitIdx;
    strb      = '0;
    if (sampleEn) begin
      case (state)
        S_IDLE: begin
          if (lastS && !rxS) begin
            stateNxt        = S_START;
            tickNxt         = '0;
            strb.clearShift = 1'b1;
          end
        end
        S_START: begin
          if (tick == MID) begin
            tickNxt   = '0;
            bitIdxNxt = '0;
            stateNxt  = rxS ? S_IDLE : S_DATA;
          end else begin
            tickNxt = tick + 1'b1;
          end
        end
        S_DATA: begin
          if (tick == LAST) begin
            tickNxt       = '0;
            strb.shiftBit = 1'b1;
            if (bitIdx == lastIdx) begin
              stateNxt = parOn ? S_PAR : S_STOP;
            end else begin
              bitIdxNxt = bitIdx + 1'b1;
            end
          end else begin
            tickNxt = tick + 1'b1;
          end
        end
        S_PAR: begin
          if (tick == LAST) begin
            tickNxt       = '0;
            strb.latchPar = 1'b1;
            stateNxt      = S_STOP;
          end else begin
            tickNxt = tick + 1'b1;
          end
        end
        S_STOP: begin
          if (tick == LAST) begin
            tickNxt   = '0;
            strb.push = 1'b1;
            stateNxt  = (!rxS && charZero) ? S_BRK : S_IDLE;
          end else begin
            tickNxt = tick + 1'b1;
          end
        end
        S_BRK: begin
          if (!rxS) begin
            tickNxt = '0;
          end else if (tick == MID) begin
            tickNxt  = '0;
            stateNxt = S_IDLE;
          end else begin
            tickNxt = tick + 1'b1;
          end
        end
        default: stateNxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      tick   <= '0;
      bitIdx <= '0;
      lastS  <= 1'b1;
    end else begin
      state  <= stateNxt;
      tick   <= tickNxt;
      bitIdx <= bitIdxNxt;
      if (sampleEn) lastS <= rxS;
    end
  end

endmodule

// File: rtl/uartrx_fifo.sv
module uartrx_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doWr, doRd;

  assign empty  = (count == '0);
  assign full   = (count == CNT_FULL);
  assign doWr   = wrEn && !full;
  assign doRd   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      if (doWr && !doRd)      count <= count + 1'b1;
      else if (doRd && !doWr) count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/uartrx_dp.sv
module uartrx_dp
  import uartrx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxd,
  input  rxStrobe_t  strb,
  input  logic [1:0] charLen,
  input  logic [1:0] parMode,
  input  logic       parOdd,
  input  logic       popReq,
  input  logic       clrErr,
  output logic       rxS,
  output logic       charZero,
  output rxEntry_t   head,
  output logic       empty,
  output logic       full,
  output logic       overrun
);

  logic [1:0] syncR;
  logic [7:0] shReg;
  logic       parBit;
  logic [7:0] aligned;
  logic       expPar;
  rxEntry_t   newEntry;
  logic [ENTRY_W-1:0] headRaw;

  assign rxS = syncR[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncR   <= 2'b11;
      shReg   <= '0;
      parBit  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      syncR <= {syncR[0], rxd};
      if (strb.clearShift) begin
        shReg  <= '0;
        parBit <= 1'b0;
      end else begin
        if (strb.shiftBit) shReg  <= {rxS, shReg[7:1]};
        if (strb.latchPar) parBit <= rxS;
      end
      if (clrErr)                 overrun <= 1'b0;
      else if (strb.push && full) overrun <= 1'b1;
    end
  end

  assign charZero = (shReg == '0) && !parBit;

  always_comb begin
    case (charLen)
      2'd0:    aligned = {3'b000, shReg[7:3]};
      2'd1:    aligned = {2'b00, shReg[7:2]};
      2'd2:    aligned = {1'b0, shReg[7:1]};
      default: aligned = shReg;
    endcase
  end

  assign expPar = (^aligned) ^ parOdd;

  always_comb begin
    newEntry.data = aligned;
    newEntry.fe   = !rxS;
    newEntry.brk  = charZero && !rxS;
    case (parMode)
      2'b00:   newEntry.pe = (parBit != expPar);
      2'b01:   newEntry.pe = (parBit != parOdd);
      2'b10:   newEntry.pe = 1'b0;
      default: newEntry.pe = parBit;
    endcase
  end

  uartrx_fifo #(
    .WIDTH(ENTRY_W),
    .DEPTH(DEPTH)
  ) u_fifo (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strb.push),
    .wrData (newEntry),
    .rdEn   (popReq),
    .rdData (headRaw),
    .empty  (empty),
    .full   (full)
  );

  assign head = rxEntry_t'(headRaw);

endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uartrx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  input  logic       rxd,
  input  logic [1:0] charLen,
  input  logic [1:0] parMode,
  input  logic       parOdd,
  input  logic       popReq,
  input  logic       clrErr,
  output logic [7:0] rxData,
  output logic       statBreak,
  output logic       statFrame,
  output logic       statParity,
  output logic       rxRdy,
  output logic       fifoFull,
  output logic       overrun
);

  rxStrobe_t strb;
  rxEntry_t  head;
  logic      rxS, charZero, empty;

  uartrx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .rxS      (rxS),
    .charZero (charZero),
    .charLen  (charLen),
    .parOn    (parMode != 2'b10),
    .strb     (strb)
  );

  uartrx_dp #(.DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rxd      (rxd),
    .strb     (strb),
    .charLen  (charLen),
    .parMode  (parMode),
    .parOdd   (parOdd),
    .popReq   (popReq),
    .clrErr   (clrErr),
    .rxS      (rxS),
    .charZero (charZero),
    .head     (head),
    .empty    (empty),
    .full     (fifoFull),
    .overrun  (overrun)
  );

  assign rxRdy      = !empty;
  assign rxData     = rxRdy ? head.data : 8'h00;
  assign statBreak  = rxRdy && head.brk;
  assign statFrame  = rxRdy && head.fe;
  assign statParity = rxRdy && head.pe;

endmodule

// File: rtl/uartrx_chk.sv
module uartrx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       popReq,
  input logic       clrErr,
  input logic [7:0] rxData,
  input logic       statBreak,
  input logic       statFrame,
  input logic       statParity,
  input logic       rxRdy,
  input logic       fifoFull,
  input logic       overrun
);

  a_r9_full_implies_rdy: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> rxRdy);

  a_r9_empty_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rxRdy |-> (rxData == 8'h00 && !statBreak && !statFrame && !statParity));

  a_r9_hold_without_pop: assert property (@(posedge clk) disable iff (!rstN)
    (rxRdy && !popReq) |=> rxRdy);

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !clrErr) |=> overrun);

  a_r10_overrun_when_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(fifoFull));

  a_r11_clear_overrun: assert property (@(posedge clk) disable iff (!rstN)
    clrErr |=> !overrun);

  a_r7_break_entry_shape: assert property (@(posedge clk) disable iff (!rstN)
    (rxRdy && statBreak) |-> (statFrame && rxData == 8'h00));

endmodule

bind uart_rx_brk uartrx_chk u_chk (.*);

// File: tb/sim_uart_rx_brk.sv
`timescale 1ns/1ps
module sim_uart_rx_brk;

  localparam int BIT = 64;   // 16 sample enables, one every 4 clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleEn = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] charLen = 2'b11;
  logic [1:0] parMode = 2'b10;
  logic       parOdd = 1'b0;
  logic       popReq = 1'b0;
  logic       clrErr = 1'b0;
  logic [7:0] rxData;
  logic       statBreak, statFrame, statParity, rxRdy, fifoFull, overrun;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [1:0] divCnt = '0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    divCnt   <= divCnt + 1'b1;
    sampleEn <= (divCnt == 2'd3);
  end

  uart_rx_brk u0 (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxd(rxd),
    .charLen(charLen), .parMode(parMode), .parOdd(parOdd),
    .popReq(popReq), .clrErr(clrErr), .rxData(rxData),
    .statBreak(statBreak), .statFrame(statFrame), .statParity(statParity),
    .rxRdy(rxRdy), .fifoFull(fifoFull), .overrun(overrun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int n, input bit withPar,
                           input bit pb, input bit stopB);
    @(negedge clk);
    rxd = 1'b0; waitClk(BIT);
    for (int i = 0; i < n; i++) begin
      rxd = d[i]; waitClk(BIT);
    end
    if (withPar) begin
      rxd = pb; waitClk(BIT);
    end
    rxd = stopB; waitClk(BIT);
    rxd = 1'b1; waitClk(2 * BIT);
  endtask

  task automatic popExpect(input string req, input int d, input bit b, input bit f, input bit p);
    @(negedge clk);
    chk(req, "rxRdy", rxRdy, 1);
    chk(req, "rxData", rxData, d);
    chk(req, "statBreak", statBreak, b);
    chk(req, "statFrame", statFrame, f);
    chk(req, "statParity", statParity, p);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "rxRdy", rxRdy, 0);
    chk("R1", "fifoFull", fifoFull, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "rxData", rxData, 0);
    chk("R1", "status", {statBreak, statFrame, statParity}, 0);
  endtask

  task automatic t_lengths;
    charLen = 2'b11; parMode = 2'b10;
    sendFrame(8'hA5, 8, 0, 0, 1);
    popExpect("R3", 8'hA5, 0, 0, 0);
    charLen = 2'b00;
    sendFrame(8'h16, 5, 0, 0, 1);
    popExpect("R3", 8'h16, 0, 0, 0);
    charLen = 2'b10;
    sendFrame(8'h5B, 7, 0, 0, 1);
    popExpect("R3", 8'h5B, 0, 0, 0);
    @(negedge clk);
    chk("R9", "rxRdy after pops", rxRdy, 0);
    charLen = 2'b11;
  endtask

  task automatic t_glitch;
    @(negedge clk);
    rxd = 1'b0; waitClk(16);
    rxd = 1'b1; waitClk(12 * BIT);
    chk("R2", "rxRdy after glitch", rxRdy, 0);
  endtask

  task automatic t_frame;
    parMode = 2'b10;
    sendFrame(8'h3C, 8, 0, 0, 0);
    popExpect("R4", 8'h3C, 0, 1, 0);
    @(negedge clk);
    chk("R4", "single entry", rxRdy, 0);
  endtask

  task automatic t_parity;
    parMode = 2'b00; parOdd = 1'b0;
    sendFrame(8'h07, 8, 1, 1, 1);
    popExpect("R5", 8'h07, 0, 0, 0);
    sendFrame(8'h07, 8, 1, 0, 1);
    popExpect("R5", 8'h07, 0, 0, 1);
    parOdd = 1'b1;
    sendFrame(8'h07, 8, 1, 0, 1);
    popExpect("R5", 8'h07, 0, 0, 0);
    parMode = 2'b01; parOdd = 1'b1;
    sendFrame(8'h30, 8, 1, 1, 1);
    popExpect("R5", 8'h30, 0, 0, 0);
    sendFrame(8'h30, 8, 1, 0, 1);
    popExpect("R5", 8'h30, 0, 0, 1);
    parMode = 2'b10; parOdd = 1'b0;
  endtask

  task automatic t_multidrop;
    parMode = 2'b11;
    sendFrame(8'h41, 8, 1, 1, 1);
    popExpect("R6", 8'h41, 0, 0, 1);
    sendFrame(8'h41, 8, 1, 0, 1);
    popExpect("R6", 8'h41, 0, 0, 0);
    parMode = 2'b10;
  endtask

  task automatic t_break;
    @(negedge clk);
    rxd = 1'b0; waitClk(20 * BIT);
    rxd = 1'b1; waitClk(2 * BIT);
    popExpect("R7", 0, 1, 1, 0);
    @(negedge clk);
    chk("R7", "only one break entry", rxRdy, 0);
  endtask

  task automatic t_breakWait;
    @(negedge clk);
    rxd = 1'b0; waitClk(12 * BIT);
    rxd = 1'b1; waitClk(16);
    sendFrame(8'hFF, 8, 0, 0, 1);
    popExpect("R8", 0, 1, 1, 0);
    @(negedge clk);
    chk("R8", "early character dropped", rxRdy, 0);
    sendFrame(8'h5A, 8, 0, 0, 1);
    popExpect("R8", 8'h5A, 0, 0, 0);
  endtask

  task automatic t_overrun;
    parMode = 2'b10;
    for (int k = 0; k < 4; k++) sendFrame(8'h10 + 8'(k), 8, 0, 0, 1);
    @(negedge clk);
    chk("R9", "fifoFull", fifoFull, 1);
    chk("R10", "overrun before", overrun, 0);
    sendFrame(8'hEE, 8, 0, 0, 1);
    @(negedge clk);
    chk("R10", "overrun set", overrun, 1);
    for (int k = 0; k < 4; k++) popExpect("R10", 8'h10 + k, 0, 0, 0);
    @(negedge clk);
    chk("R10", "dropped char absent", rxRdy, 0);
    chk("R10", "overrun sticky", overrun, 1);
    clrErr = 1'b1;
    @(negedge clk);
    clrErr = 1'b0;
    chk("R11", "overrun cleared", overrun, 0);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(BIT);
    t_reset();
    t_lengths();
    t_glitch();
    t_frame();
    t_parity();
    t_multidrop();
    t_break();
    t_breakWait();
    t_overrun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule